// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 16-bit successive-approximation converter. The analog side consists of a binary-weighted capacitor DAC and a comparator. The sequencer drives one switch control per DAC element. A `1` ties that element to the reference and a `0` ties it to reference ground. The sequencer reads back a single comparator bit and runs a binary search from the heaviest element down to the lightest. Each trial halves the weight of the one before it.

A falling edge on the active-low start input launches a conversion. `busy` stays high while the trials run. When the lightest bit has been decided, the code is latched onto `code` and `busy` drops. There is no pipeline: the code belongs to the sample that was just taken. Two mode inputs set how many clock cycles each trial lasts, which gives a fast, a normal and a low-power conversion time.

The fast timing only holds its accuracy when conversions come close together. For this reason the block counts idle clock cycles between conversions, scaled from a clock-frequency parameter to a 1 ms limit. A fast conversion that follows a longer gap, or that is the first conversion after reset, finishes with `resultValid` low.

Top module: `sar_sequencer`

## Requirements
- R1: While `busy` is low, a high-to-low transition of `convStartN` (seen at two successive rising clock edges) starts a conversion, and `busy` is high from the second of those edges.
- R2: Each conversion keeps `busy` high for exactly 16 × step clock cycles. The step length is taken from `warpSel`/`impulseSel` at the starting edge: `warpSel`=1 gives the fast step (11 cycles, and warp wins when both inputs are high); `warpSel`=0 with `impulseSel`=1 gives the low-power step (13 cycles); both low gives the normal step (12 cycles).
- R3: In the first cycle of `busy`, `dacSwitch` equals 16'h8000, so only bit 15 is tried. Bits are then tried one at a time from bit 15 down to bit 0.
- R4: A trial bit stays 1 when `compHigh` is 1 on the last cycle of its step, and is cleared otherwise. With an ideal comparator (`compHigh` = `dacSwitch` ≤ input), `code` equals the input value from the cycle `busy` falls onward, and `code` does not change while `busy` is high.
- R5: A falling edge of `convStartN` while `busy` is high is ignored. The conversion length and code are unaffected, and no new conversion follows.
- R6: `resultValid` is updated only when a conversion ends. It is 0 if the conversion ran in fast mode and more than CLK_HZ/1000 clock cycles passed between the end of the previous conversion (or reset) and the starting edge. Otherwise it is 1.
- R7: Synchronous reset (`rst`=1) clears `busy`, `code`, `dacSwitch` and `resultValid`, aborts any conversion, and counts as an expired idle limit.
- R8: Changing `warpSel`/`impulseSel` during a conversion does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| convStartN | input | 1 | Conversion start, falling edge triggers |
| warpSel | input | 1 | Selects the fast step timing |
| impulseSel | input | 1 | Selects the low-power step timing when warpSel is low |
| compHigh | input | 1 | Comparator: 1 when the DAC level does not exceed the sample |
| dacSwitch | output | 16 | DAC element controls, 1 = reference, 0 = reference ground |
| busy | output | 1 | High while a conversion runs |
| code | output | 16 | Last converted code |
| resultValid | output | 1 | Low when the last result may be inaccurate |

## Verification
The checker watches four things on every cycle. It checks that `busy` only rises after a low start input. It checks that the first trial pattern is the MSB alone. It checks that `code` holds during a conversion and matches the switch pattern when `busy` falls. It checks that `busy` lasts the step count of the mode captured at the start, and that `resultValid` moves only at the end of a conversion. Some behaviour needs full scenarios, which the bench provides by driving an ideal comparator against many input values in every mode. These are:
- that the binary search actually lands on the input value;
- that the idle limit flips exactly between a gap of 1 ms and one cycle more;
- that a reset in mid-conversion marks the next fast result as untrustworthy.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FAST   = 2'd1,
    MODE_LOWPWR = 2'd2
  } convMode_t;

  typedef struct packed {
    logic start;    // conversion launched this cycle
    logic resolve;  // current trial bit is decided this cycle
    logic finish;   // last trial bit is decided this cycle
    logic stale;    // running conversion began after an expired idle gap in fast mode
  } seqStrobe_t;

  function automatic convMode_t decodeMode(input logic warp, input logic impulse);
    if (warp)         return MODE_FAST;
    else if (impulse) return MODE_LOWPWR;
    else              return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int STEP_FAST   = 11,
  parameter int STEP_NORMAL = 12,
  parameter int STEP_LOWPWR = 13,
  parameter int IDLE_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             convStartN,
  input  logic             warpSel,
  input  logic             impulseSel,
  output seqStrobe_t       strobe,
  output logic [WIDTH-1:0] curMask,
  output logic             busy
);

  localparam int MAX_A    = (STEP_FAST > STEP_NORMAL) ? STEP_FAST : STEP_NORMAL;
  localparam int MAX_STEP = (MAX_A > STEP_LOWPWR) ? MAX_A : STEP_LOWPWR;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);
  localparam int IDX_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int IDLE_W   = $clog2(IDLE_CYCLES + 1);

  logic              startPrev;
  logic              startFall;
  convMode_t         reqMode;
  logic [STEP_W-1:0] reqStep;
  logic [STEP_W-1:0] stepLen;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              stepDone;
  logic              staleReg;
  logic [IDLE_W-1:0] idleCnt;
  logic              idleExpired;

  // start-edge detection
  always_ff @(posedge clk) begin
    if (rst) startPrev <= 1'b1;
    else     startPrev <= convStartN;
  end
  assign startFall = startPrev & ~convStartN;

  // mode decode to per-trial step length
  assign reqMode = decodeMode(warpSel, impulseSel);
  always_comb begin
    unique case (reqMode)
      MODE_FAST:   reqStep = STEP_W'(STEP_FAST);
      MODE_LOWPWR: reqStep = STEP_W'(STEP_LOWPWR);
      default:     reqStep = STEP_W'(STEP_NORMAL);
    endcase
  end

  assign stepDone = (stepCnt == stepLen - STEP_W'(1));

  // trial sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bitIdx   <= '0;
      stepCnt  <= '0;
      stepLen  <= '0;
      staleReg <= 1'b0;
    end else if (!busy) begin
      if (startFall) begin
        busy     <= 1'b1;
        bitIdx   <= IDX_W'(WIDTH - 1);
        stepCnt  <= '0;
        stepLen  <= reqStep;
        staleReg <= idleExpired && (reqMode == MODE_FAST);
      end
    end else if (stepDone) begin
      stepCnt <= '0;
      if (bitIdx == '0) busy   <= 1'b0;
      else              bitIdx <= bitIdx - IDX_W'(1);
    end else begin
      stepCnt <= stepCnt + STEP_W'(1);
    end
  end

  // idle gap timer: counts cycles since the last conversion ended
  always_ff @(posedge clk) begin
    if (rst) begin
      idleCnt     <= '0;
      idleExpired <= 1'b1;
    end else if (strobe.finish) begin
      idleCnt     <= '0;
      idleExpired <= 1'b0;
    end else if (!busy && !idleExpired) begin
      if (idleCnt == IDLE_W'(IDLE_CYCLES - 1)) idleExpired <= 1'b1;
      else                                     idleCnt     <= idleCnt + IDLE_W'(1);
    end
  end

  always_comb begin
    strobe.start   = !busy && startFall;
    strobe.resolve = busy && stepDone;
    strobe.finish  = busy && stepDone && (bitIdx == '0);
    strobe.stale   = staleReg;
  end

  assign curMask = busy ? (WIDTH'(1) << bitIdx) : '0;

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [WIDTH-1:0] curMask,
  input  logic             compHigh,
  output logic [WIDTH-1:0] dacSwitch,
  output logic [WIDTH-1:0] code,
  output logic             resultValid
);

  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialReg;
  logic [WIDTH-1:0] decided;
  logic [WIDTH-1:0] nextMask;

  assign decided  = (trialReg & ~curMask) | (compHigh ? curMask : '0);
  assign nextMask = strobe.finish ? '0 : (curMask >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      trialReg    <= '0;
      code        <= '0;
      resultValid <= 1'b0;
    end else if (strobe.start) begin
      trialReg <= MSB_MASK;
    end else if (strobe.resolve) begin
      trialReg <= decided | nextMask;
      if (strobe.finish) begin
        code        <= decided;
        resultValid <= ~strobe.stale;
      end
    end
  end

  assign dacSwitch = trialReg;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CLK_HZ      = 100_000_000,
  parameter int STEP_FAST   = 11,
  parameter int STEP_NORMAL = 12,
  parameter int STEP_LOWPWR = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             convStartN,
  input  logic             warpSel,
  input  logic             impulseSel,
  input  logic             compHigh,
  output logic [WIDTH-1:0] dacSwitch,
  output logic             busy,
  output logic [WIDTH-1:0] code,
  output logic             resultValid
);

  localparam int IDLE_CYCLES = CLK_HZ / 1000;

  seqStrobe_t       strobe;
  logic [WIDTH-1:0] curMask;

  sar_seq_ctrl #(
    .WIDTH(WIDTH), .STEP_FAST(STEP_FAST), .STEP_NORMAL(STEP_NORMAL),
    .STEP_LOWPWR(STEP_LOWPWR), .IDLE_CYCLES(IDLE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .convStartN(convStartN), .warpSel(warpSel),
    .impulseSel(impulseSel), .strobe(strobe), .curMask(curMask), .busy(busy)
  );

  sar_seq_datapath #(.WIDTH(WIDTH)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .curMask(curMask), .compHigh(compHigh),
    .dacSwitch(dacSwitch), .code(code), .resultValid(resultValid)
  );

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int WIDTH       = 16,
  parameter int STEP_FAST   = 11,
  parameter int STEP_NORMAL = 12,
  parameter int STEP_LOWPWR = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             convStartN,
  input logic             warpSel,
  input logic             impulseSel,
  input logic [WIDTH-1:0] dacSwitch,
  input logic             busy,
  input logic [WIDTH-1:0] code,
  input logic             resultValid
);

  logic [31:0] busyCnt;
  logic [31:0] pendStep;

  always_ff @(posedge clk) begin
    if (rst) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 32'd1;
    else busyCnt <= '0;
  end

  // step length of the mode that a start on this edge would capture
  always_ff @(posedge clk) begin
    if (rst) pendStep <= 32'(STEP_NORMAL);
    else if (!busy)
      pendStep <= warpSel ? 32'(STEP_FAST) : (impulseSel ? 32'(STEP_LOWPWR) : 32'(STEP_NORMAL));
  end

  assert_start_on_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!convStartN));

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dacSwitch == {1'b1, {(WIDTH-1){1'b0}}});

  // covers R2, R5 and R8 together: length fixed by the mode captured at start
  assert_busy_length_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busyCnt == WIDTH * pendStep);

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(code));

  assert_code_match_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> code == dacSwitch);

  assert_valid_only_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$fell(busy)) |-> $stable(resultValid));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!busy && code == '0 && dacSwitch == '0 && !resultValid));

endmodule

bind sar_sequencer sar_sequencer_chk #(
  .WIDTH(WIDTH), .STEP_FAST(STEP_FAST), .STEP_NORMAL(STEP_NORMAL), .STEP_LOWPWR(STEP_LOWPWR)
) u_chk (
  .clk(clk), .rst(rst), .convStartN(convStartN), .warpSel(warpSel), .impulseSel(impulseSel),
  .dacSwitch(dacSwitch), .busy(busy), .code(code), .resultValid(resultValid)
);

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 100_000;
  localparam int IDLE       = TB_CLK_HZ / 1000;
  localparam int NBITS      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        convStartN = 1'b1;
  logic        warpSel = 1'b0;
  logic        impulseSel = 1'b0;
  logic [15:0] vinModel = 16'h0000;
  logic        compHigh;
  logic [15:0] dacSwitch;
  logic        busy;
  logic [15:0] code;
  logic        resultValid;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: DAC level not above the held sample
  assign compHigh = (dacSwitch <= vinModel);

  sar_sequencer #(.WIDTH(NBITS), .CLK_HZ(TB_CLK_HZ)) u_sar_sequencer (
    .clk(clk), .rst(rst), .convStartN(convStartN), .warpSel(warpSel),
    .impulseSel(impulseSel), .compHigh(compHigh), .dacSwitch(dacSwitch),
    .busy(busy), .code(code), .resultValid(resultValid)
  );

  function automatic int stepOf(input bit w, input bit imp);
    return w ? 11 : (imp ? 13 : 12);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one conversion; gap = idle negedges before dropping the start input
  task automatic convert(input bit w, input bit imp, input logic [15:0] v,
                         input int gap, input bit expValid, input bit poke);
    int cnt;
    int expLen;
    warpSel = w; impulseSel = imp; vinModel = v;
    repeat (gap) @(negedge clk);
    convStartN = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    chk(dacSwitch == 16'h8000, "R3 first trial", 32'(dacSwitch), 32'h8000);
    convStartN = 1'b1;
    cnt = 1;
    if (poke) begin warpSel = ~w; impulseSel = ~imp; end  // R8 mode change mid-run
    while (busy) begin
      @(negedge clk);
      if (busy) cnt++;
      if (poke && cnt == 40) convStartN = 1'b0;  // R5 edge while busy
      if (poke && cnt == 44) convStartN = 1'b1;
    end
    expLen = NBITS * stepOf(w, imp);
    chk(cnt == expLen, "R2 R8 busy length", 32'(cnt), 32'(expLen));
    chk(code == v, "R4 R5 code", 32'(code), 32'(v));
    chk(resultValid == expValid, "R6 resultValid", 32'(resultValid), 32'(expValid));
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b0, "R5 no retrigger", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", 32'(busy), 32'd0);
    chk(code == 16'h0, "R7 reset code", 32'(code), 32'd0);
    chk(dacSwitch == 16'h0, "R7 reset switches", 32'(dacSwitch), 32'd0);
    chk(resultValid == 1'b0, "R7 reset valid", 32'(resultValid), 32'd0);
    rst = 1'b0;

    // idle-limit boundaries
    convert(1'b1, 1'b0, 16'h1234, 0, 1'b0, 1'b0);        // R6 first fast after reset
    convert(1'b1, 1'b0, 16'h4321, 2, 1'b1, 1'b0);
    convert(1'b1, 1'b0, 16'hBEEF, IDLE - 1, 1'b1, 1'b0); // gap exactly at limit
    convert(1'b1, 1'b0, 16'h0F0F, IDLE, 1'b0, 1'b0);     // one cycle over
    convert(1'b0, 1'b0, 16'hCAFE, IDLE + 40, 1'b1, 1'b0); // normal mode ignores gap
    convert(1'b0, 1'b1, 16'h00FF, IDLE + 40, 1'b1, 1'b0); // low-power ignores gap
    convert(1'b1, 1'b1, 16'h7E81, 0, 1'b1, 1'b0);        // R2 warp wins over impulse

    // sweep of corners and spread values over all three modes
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] v;
        case (k)
          0: v = 16'h0000;
          1: v = 16'hFFFF;
          2: v = 16'h8000;
          3: v = 16'h7FFF;
          4: v = 16'h0001;
          5: v = 16'hFFFE;
          6: v = 16'h5555;
          7: v = 16'hAAAA;
          default: v = 16'((k * 40503 + m * 977) & 16'hFFFF);
        endcase
        convert(m == 0, m == 2, v, 1, 1'b1, 1'b0);
      end
    end

    // mode change and start edge while busy
    convert(1'b0, 1'b0, 16'h3C5A, 1, 1'b1, 1'b1);
    convert(1'b0, 1'b1, 16'hA5C3, 1, 1'b1, 1'b1);

    // reset during a conversion
    warpSel = 1'b0; impulseSel = 1'b0; vinModel = 16'hFFFF;
    convStartN = 1'b0;
    @(negedge clk);
    convStartN = 1'b1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7 abort busy", 32'(busy), 32'd0);
    chk(dacSwitch == 16'h0, "R7 abort switches", 32'(dacSwitch), 32'd0);
    chk(code == 16'h0, "R7 abort code", 32'(code), 32'd0);
    rst = 1'b0;
    convert(1'b1, 1'b0, 16'h2468, 0, 1'b0, 1'b0);  // R7 reset marks idle limit expired
    convert(1'b1, 1'b0, 16'h1357, 0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule